// File: doc/BRIEF.md
# Virtual-Pool Receive Queue Selector

This block decides which receive queues a frame goes to when the receive side is split into virtual pools. It has eight pools and sixteen queues. It takes the destination address of a parsed frame and the classification done upstream (broadcast, unicast address-filter hit and the pools that hit). It then combines these with per-pool accept controls, a multicast hash table and a default pool to form an eight-bit pool set. A per-pool receive-enable mask gates that set. The low bit of the queue chosen by the flow hash then places the set in the lower or the upper half of the queues.

When pool mode is off, the pool logic has no effect. The flow-hash queue number is passed out as a one-hot queue mask instead.

The selector is one registered pipeline stage. A valid strobe travels with the data. The queue mask is held between valid frames, so a downstream stage can sample it whenever the valid strobe is high.

Top module: `rxps_top`

## Requirements
- R1: While `rst_n` is low, and after reset until the first valid frame, `out_valid` is 0 and `queue_mask` is 0.
- R2: `out_valid` equals `in_valid` of the previous clock. `queue_mask` is loaded only in a cycle after `in_valid` was 1, and holds its value otherwise, whatever the other inputs do.
- R3: In pool mode, a frame with `is_bcast`=1 selects exactly the pools whose bit is set in `pool_bcast_acc`. Broadcast takes precedence over the multicast and unicast rules.
- R4: For a multicast frame (`dst_mac[0]`=1, not broadcast), the 12-bit hash index is the 16-bit value {`dst_mac[47:40]`, `dst_mac[39:32]`} shifted right by 4, 3, 2 or 0 for `mc_offset` = 0, 1, 2 or 3, keeping the low 12 bits. The index selects bit f of `mc_table`, which is word f[11:5], bit f[4:0].
- R5: A multicast frame whose hash bit is set selects the pools set in `pool_mc_acc`. A multicast frame whose hash bit is clear selects no pool by that rule.
- R6: A unicast frame (`dst_mac[0]`=0) with `uc_match`=1 selects the pools in `uc_pools`. With `uc_match`=0 it selects the pools set in `pool_untag_acc`.
- R7: If the rules above select no pool, the single pool numbered `default_pool` is selected.
- R8: The pool set, after the default rule, is ANDed with `pool_rx_en`. A pool whose enable is clear never appears in the output, even when it is the default pool, and the mask may then be all zero.
- R9: In pool mode, if `rss_queue[0]` is 0, the gated pool set drives `queue_mask[7:0]` and `queue_mask[15:8]` is 0. If `rss_queue[0]` is 1, the set drives `queue_mask[15:8]` and `queue_mask[7:0]` is 0.
- R10: With `pool_mode`=0, `queue_mask` is one-hot at bit `rss_queue`, and the pool controls, the hash table and the address have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Frame descriptor valid this cycle |
| dst_mac | input | 48 | Destination address, byte 0 in bits 7:0, byte 5 in bits 47:40 |
| is_bcast | input | 1 | Frame is broadcast |
| uc_match | input | 1 | Unicast address filter hit |
| uc_pools | input | 8 | Pools that the unicast filter hit |
| pool_bcast_acc | input | 8 | Per-pool broadcast accept |
| pool_mc_acc | input | 8 | Per-pool multicast-hash accept |
| pool_untag_acc | input | 8 | Per-pool accept for unmatched unicast |
| mc_table | input | 4096 | Multicast hash table, 128 words of 32 bits, word w in bits 32w+31:32w |
| mc_offset | input | 2 | Hash shift select |
| default_pool | input | 3 | Pool used when no rule selects one |
| pool_rx_en | input | 8 | Per-pool receive enable |
| pool_mode | input | 1 | Pool mode on |
| rss_queue | input | 4 | Queue chosen by the flow hash |
| out_valid | output | 1 | Queue mask valid |
| queue_mask | output | 16 | Selected receive queues |

## Verification
Every result is due exactly one clock after the edge that samples the valid frame. No result needs more than one cycle. Inputs are changed just after a falling edge and are captured at the next rising edge. The bench model updates its expected mask at that point. The outputs are compared at the following falling edge, one cycle after the stimulus. The comparison is made on every clock, so cycles without a valid frame also check that the mask holds.

// File: rtl/rxps_pkg.sv
package rxps_pkg;

   typedef enum logic [1:0] {
      FC_BCAST     = 2'd0,
      FC_MCAST     = 2'd1,
      FC_UCAST_HIT = 2'd2,
      FC_UCAST_MISS= 2'd3
   } frame_class_e;

   // right-shift applied to the 16-bit hash source per offset select
   function automatic int unsigned mc_shift(input logic [1:0] sel);
      case (sel)
         2'd0:    return 4;
         2'd1:    return 3;
         2'd2:    return 2;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/rxps_classify.sv
module rxps_classify
   import rxps_pkg::*;
(
   input  logic         is_bcast,
   input  logic         group_bit,
   input  logic         uc_match,
   output frame_class_e fclass
);

   always_comb begin
      if (is_bcast)
         fclass = FC_BCAST;
      else if (group_bit)
         fclass = FC_MCAST;
      else if (uc_match)
         fclass = FC_UCAST_HIT;
      else
         fclass = FC_UCAST_MISS;
   end

endmodule

// File: rtl/rxps_mc_hash.sv
module rxps_mc_hash
   import rxps_pkg::*;
#(
   parameter int unsigned TBL_WORDS = 128,
   parameter int unsigned WORD_W    = 32,
   parameter int unsigned SRC_W     = 16
) (
   input  logic [SRC_W-1:0]            hash_src,
   input  logic [1:0]                  offset_sel,
   input  logic [TBL_WORDS*WORD_W-1:0] table_bits,
   output logic                        hit
);

   localparam int unsigned IDX_W  = $clog2(TBL_WORDS * WORD_W);
   localparam int unsigned WSEL_W = $clog2(TBL_WORDS);
   localparam int unsigned BSEL_W = $clog2(WORD_W);

   if (IDX_W > SRC_W) begin : g_bad_idx
      $error("rxps_mc_hash: hash index wider than its source");
   end
   if ((1 << WSEL_W) != TBL_WORDS) begin : g_bad_words
      $error("rxps_mc_hash: table depth must be a power of two");
   end
   if ((1 << BSEL_W) != WORD_W) begin : g_bad_wordw
      $error("rxps_mc_hash: word width must be a power of two");
   end

   logic [WORD_W-1:0] words [TBL_WORDS];

   for (genvar w = 0; w < TBL_WORDS; w++) begin : g_word
      assign words[w] = table_bits[w*WORD_W +: WORD_W];
   end

   logic [IDX_W-1:0]  idx;
   logic [WSEL_W-1:0] wsel;
   logic [BSEL_W-1:0] bsel;
   logic [WORD_W-1:0] picked;

   always_comb begin
      idx    = IDX_W'(hash_src >> mc_shift(offset_sel));
      wsel   = idx[IDX_W-1:BSEL_W];
      bsel   = idx[BSEL_W-1:0];
      picked = words[wsel];
      hit    = picked[bsel];
   end

endmodule

// File: rtl/rxps_pool_pick.sv
module rxps_pool_pick
   import rxps_pkg::*;
#(
   parameter int unsigned NUM_POOLS = 8,
   localparam int unsigned PSEL_W   = $clog2(NUM_POOLS)
) (
   input  frame_class_e          fclass,
   input  logic                  mc_hit,
   input  logic [NUM_POOLS-1:0]  uc_pools,
   input  logic [NUM_POOLS-1:0]  bcast_acc,
   input  logic [NUM_POOLS-1:0]  mc_acc,
   input  logic [NUM_POOLS-1:0]  untag_acc,
   input  logic [PSEL_W-1:0]     default_pool,
   output logic [NUM_POOLS-1:0]  pools
);

   logic [NUM_POOLS-1:0] ruled;
   logic [NUM_POOLS-1:0] dflt;

   // per-pool membership by frame class
   for (genvar p = 0; p < NUM_POOLS; p++) begin : g_pool
      always_comb begin
         case (fclass)
            FC_BCAST:     ruled[p] = bcast_acc[p];
            FC_MCAST:     ruled[p] = mc_hit & mc_acc[p];
            FC_UCAST_HIT: ruled[p] = uc_pools[p];
            default:      ruled[p] = untag_acc[p];
         endcase
         dflt[p] = (default_pool == PSEL_W'(p));
      end
   end

   assign pools = (|ruled) ? ruled : dflt;

endmodule

// File: rtl/rxps_queue_map.sv
module rxps_queue_map #(
   parameter int unsigned NUM_POOLS  = 8,
   parameter int unsigned NUM_QUEUES = 16,
   localparam int unsigned QSEL_W    = $clog2(NUM_QUEUES)
) (
   input  logic                  pool_mode,
   input  logic [NUM_POOLS-1:0]  pools,
   input  logic [NUM_POOLS-1:0]  pool_rx_en,
   input  logic [QSEL_W-1:0]     rss_queue,
   output logic [NUM_QUEUES-1:0] qmask
);

   if (NUM_QUEUES != 2 * NUM_POOLS) begin : g_bad_ratio
      $error("rxps_queue_map: queue count must be twice the pool count");
   end

   logic [NUM_POOLS-1:0]  gated;
   logic [NUM_QUEUES-1:0] pool_q;
   logic [NUM_QUEUES-1:0] rss_q;

   assign gated = pools & pool_rx_en;

   for (genvar q = 0; q < NUM_QUEUES; q++) begin : g_q
      if (q < NUM_POOLS) begin : g_lo
         assign pool_q[q] = gated[q] & ~rss_queue[0];
      end else begin : g_hi
         assign pool_q[q] = gated[q-NUM_POOLS] & rss_queue[0];
      end
      assign rss_q[q] = (rss_queue == QSEL_W'(q));
   end

   assign qmask = pool_mode ? pool_q : rss_q;

endmodule

// File: rtl/rxps_top.sv
module rxps_top
   import rxps_pkg::*;
#(
   parameter int unsigned NUM_POOLS  = 8,
   parameter int unsigned NUM_QUEUES = 16,
   parameter int unsigned TBL_WORDS  = 128,
   parameter int unsigned WORD_W     = 32,
   localparam int unsigned PSEL_W    = $clog2(NUM_POOLS),
   localparam int unsigned QSEL_W    = $clog2(NUM_QUEUES),
   localparam int unsigned TBL_BITS  = TBL_WORDS * WORD_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic [47:0]           dst_mac,
   input  logic                  is_bcast,
   input  logic                  uc_match,
   input  logic [NUM_POOLS-1:0]  uc_pools,
   input  logic [NUM_POOLS-1:0]  pool_bcast_acc,
   input  logic [NUM_POOLS-1:0]  pool_mc_acc,
   input  logic [NUM_POOLS-1:0]  pool_untag_acc,
   input  logic [TBL_BITS-1:0]   mc_table,
   input  logic [1:0]            mc_offset,
   input  logic [PSEL_W-1:0]     default_pool,
   input  logic [NUM_POOLS-1:0]  pool_rx_en,
   input  logic                  pool_mode,
   input  logic [QSEL_W-1:0]     rss_queue,
   output logic                  out_valid,
   output logic [NUM_QUEUES-1:0] queue_mask
);

   logic [30:0] addr_unused;
   assign addr_unused = dst_mac[31:1];

   frame_class_e          fclass;
   logic                  mc_hit;
   logic [NUM_POOLS-1:0]  pools;
   logic [NUM_QUEUES-1:0] qmask_d;

   rxps_classify u_class (
      .is_bcast  (is_bcast),
      .group_bit (dst_mac[0]),
      .uc_match  (uc_match),
      .fclass    (fclass)
   );

   rxps_mc_hash #(
      .TBL_WORDS (TBL_WORDS),
      .WORD_W    (WORD_W),
      .SRC_W     (16)
   ) u_hash (
      .hash_src   (dst_mac[47:32]),
      .offset_sel (mc_offset),
      .table_bits (mc_table),
      .hit        (mc_hit)
   );

   rxps_pool_pick #(
      .NUM_POOLS (NUM_POOLS)
   ) u_pick (
      .fclass       (fclass),
      .mc_hit       (mc_hit),
      .uc_pools     (uc_pools),
      .bcast_acc    (pool_bcast_acc),
      .mc_acc       (pool_mc_acc),
      .untag_acc    (pool_untag_acc),
      .default_pool (default_pool),
      .pools        (pools)
   );

   rxps_queue_map #(
      .NUM_POOLS  (NUM_POOLS),
      .NUM_QUEUES (NUM_QUEUES)
   ) u_map (
      .pool_mode  (pool_mode),
      .pools      (pools),
      .pool_rx_en (pool_rx_en),
      .rss_queue  (rss_queue),
      .qmask      (qmask_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         queue_mask <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid)
            queue_mask <= qmask_d;
      end
   end

   // R2
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R2
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(queue_mask)));

   // R8
   rx_en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && pool_mode) |=>
         (((queue_mask[NUM_POOLS-1:0] | queue_mask[NUM_QUEUES-1:NUM_POOLS])
           & ~$past(pool_rx_en)) == '0));

   // R9
   half_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && pool_mode && rss_queue[0]) |=> (queue_mask[NUM_POOLS-1:0] == '0));

   // R10
   rss_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !pool_mode) |=> $onehot(queue_mask));

endmodule

// File: tb/rxps_top_test.sv
module rxps_top_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [47:0] dst_mac;
   logic        is_bcast;
   logic        uc_match;
   logic [7:0]  uc_pools;
   logic [7:0]  pool_bcast_acc;
   logic [7:0]  pool_mc_acc;
   logic [7:0]  pool_untag_acc;
   logic [4095:0] mc_table;
   logic [1:0]  mc_offset;
   logic [2:0]  default_pool;
   logic [7:0]  pool_rx_en;
   logic        pool_mode;
   logic [3:0]  rss_queue;
   logic        out_valid;
   logic [15:0] queue_mask;

   int checks = 0;
   int failures = 0;

   logic        exp_valid;
   logic [15:0] exp_mask;

   always #10 clk = ~clk;

   rxps_top uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dst_mac(dst_mac),
      .is_bcast(is_bcast), .uc_match(uc_match), .uc_pools(uc_pools),
      .pool_bcast_acc(pool_bcast_acc), .pool_mc_acc(pool_mc_acc),
      .pool_untag_acc(pool_untag_acc), .mc_table(mc_table),
      .mc_offset(mc_offset), .default_pool(default_pool),
      .pool_rx_en(pool_rx_en), .pool_mode(pool_mode), .rss_queue(rss_queue),
      .out_valid(out_valid), .queue_mask(queue_mask)
   );

   function automatic logic [15:0] model();
      int pools;
      int sh;
      int f;
      if (!pool_mode) return 16'(1 << rss_queue);
      if (is_bcast) pools = pool_bcast_acc;
      else if (dst_mac[0]) begin
         sh = (mc_offset == 0) ? 4 : (mc_offset == 1) ? 3 : (mc_offset == 2) ? 2 : 0;
         f = ((dst_mac[47:40] * 256 + dst_mac[39:32]) >> sh) % 4096;
         pools = mc_table[f] ? int'(pool_mc_acc) : 0;
      end else if (uc_match) pools = uc_pools;
      else pools = pool_untag_acc;
      if (pools == 0) pools = 1 << default_pool;
      pools = pools & pool_rx_en;
      if (rss_queue[0]) pools = pools * 256;
      return 16'(pools);
   endfunction

   task automatic compare(input string tag);
      checks++;
      if (out_valid !== exp_valid || queue_mask !== exp_mask) begin
         failures++;
         $display("FAIL %s: valid=%0b mask=%04h expected valid=%0b mask=%04h",
                  tag, out_valid, queue_mask, exp_valid, exp_mask);
      end
   endtask

   // inputs already set after a falling edge; expected due one cycle later
   task automatic cycle(input string tag);
      if (in_valid) exp_mask = model();
      exp_valid = in_valid;
      @(negedge clk);
      compare(tag);
   endtask

   task automatic defaults();
      in_valid = 1'b1; dst_mac = 48'h0; is_bcast = 1'b0; uc_match = 1'b0;
      uc_pools = 8'h0; pool_bcast_acc = 8'h0; pool_mc_acc = 8'h0;
      pool_untag_acc = 8'h0; mc_table = '0; mc_offset = 2'd0;
      default_pool = 3'd0; pool_rx_en = 8'hFF; pool_mode = 1'b1; rss_queue = 4'd0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      defaults();
      in_valid = 1'b0;
      rst_n = 1'b0;
      exp_valid = 1'b0;
      exp_mask = 16'h0;
      repeat (3) @(negedge clk);
      compare("R1 in reset");
      rst_n = 1'b1;
      cycle("R1 after reset");

      // R10: non-pool mode, pool inputs set but ignored
      defaults(); pool_mode = 0; rss_queue = 4'd5; pool_untag_acc = 8'hFF;
      pool_bcast_acc = 8'hFF; is_bcast = 1; pool_rx_en = 8'h00;
      cycle("R10 rss5");
      rss_queue = 4'd15; is_bcast = 0;
      cycle("R10 rss15");

      // R3: broadcast
      defaults(); is_bcast = 1; dst_mac = 48'hFFFF_FFFF_FFFF;
      pool_bcast_acc = 8'h5A; pool_mc_acc = 8'hFF; mc_table = '1;
      cycle("R3 bcast low");
      rss_queue = 4'd3;
      cycle("R3 R9 bcast high");

      // R4/R5: multicast hash index per offset, source 0xA73C
      defaults(); dst_mac = 48'hA73C_0000_0001; pool_mc_acc = 8'h81; default_pool = 3'd2;
      mc_table[12'hA73] = 1'b1; mc_offset = 2'd0;
      cycle("R4 off0");
      mc_table = '0; mc_table[12'h4E7] = 1'b1; mc_offset = 2'd1;
      cycle("R4 off1");
      mc_table = '0; mc_table[12'h9CF] = 1'b1; mc_offset = 2'd2;
      cycle("R4 off2");
      mc_table = '0; mc_table[12'h73C] = 1'b1; mc_offset = 2'd3;
      cycle("R4 off3");
      mc_offset = 2'd0;
      cycle("R5 hash miss to default");

      // R6: unicast
      defaults(); dst_mac = 48'h1234_5678_9AB0; uc_match = 1; uc_pools = 8'h24;
      pool_untag_acc = 8'h03;
      cycle("R6 uc hit");
      uc_match = 0;
      cycle("R6 uc miss untagged");

      // R7: nothing selected -> default pool
      pool_untag_acc = 8'h00; default_pool = 3'd6;
      cycle("R7 default");
      rss_queue = 4'd1;
      cycle("R7 R9 default high");

      // R8: enable gating
      defaults(); is_bcast = 1; pool_bcast_acc = 8'h0F; pool_rx_en = 8'h03;
      cycle("R8 gated bcast");
      is_bcast = 0; default_pool = 3'd4; pool_rx_en = 8'hEF;
      cycle("R8 default disabled");

      // R2: idle cycles keep mask while inputs move
      defaults(); is_bcast = 1; pool_bcast_acc = 8'h33;
      cycle("R2 load");
      in_valid = 0; pool_bcast_acc = 8'hCC; rss_queue = 4'd1;
      cycle("R2 hold 1");
      pool_mode = 0;
      cycle("R2 hold 2");

      // mixed random traffic
      for (int i = 0; i < 400; i++) begin
         in_valid = ($urandom_range(0, 3) != 0);
         dst_mac = {$urandom(), $urandom()} & 48'hFFFF_FFFF_FFFF;
         is_bcast = ($urandom_range(0, 5) == 0);
         uc_match = $urandom_range(0, 1);
         uc_pools = 8'($urandom());
         pool_bcast_acc = 8'($urandom());
         pool_mc_acc = 8'($urandom());
         pool_untag_acc = ($urandom_range(0, 2) == 0) ? 8'h00 : 8'($urandom());
         for (int w = 0; w < 128; w++) mc_table[w*32 +: 32] = $urandom();
         mc_offset = 2'($urandom());
         default_pool = 3'($urandom());
         pool_rx_en = 8'($urandom());
         pool_mode = ($urandom_range(0, 4) != 0);
         rss_queue = 4'($urandom());
         cycle("R3-R10 mixed");
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule